// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full `2*WIDTH`-bit product. A grid of cells, one per operand bit pair, forms each partial-product bit with an AND gate and folds it into a running sum and carry pair. Each row of cells handles one bit of the second operand and retires one low bit of the product. A two-level carry-lookahead adder then merges the sum and carry vectors left by the last row. The result is the upper half of the product.

The parameter `STAGES` sets how many register levels are spread evenly over the row boundaries. The operands, the sum and carry vectors and the retired low bits travel through every level together. Each row therefore always works on its own operand pair, and a new pair can enter on every clock. With `STAGES` at zero the block is purely combinational. The valid flag runs beside the data and is the only state that reset touches.

Top module: `csa_array_mult`

## Requirements
- R1: When `out_valid` is 1, `product` equals the unsigned product of the `op_a` and `op_b` that entered with the matching `in_valid`, over all `2*WIDTH` bits.
- R2: `out_valid` equals `in_valid` delayed by exactly `STAGES` rising edges of `clk`. With `STAGES` = 0 it follows `in_valid` in the same cycle, and `product` is a combinational function of the operands.
- R3: A new operand pair can be presented on every cycle. Back-to-back pairs each produce their own product, in order and one cycle apart, with no mixing between neighbours.
- R4: When `STAGES` >= 1, `rst_n` sampled low at a rising edge clears every valid bit. `out_valid` is 0 after that edge, and a pair that was in flight at that edge never appears as valid. Data registers are not reset.
- R5: A zero operand gives a product of 0. Two all-ones operands give (2^WIDTH - 1)^2.
- R6: `STAGES` may take any value from 0 to `WIDTH`, and the latency is exactly `STAGES` for every such value, including small widths with several stages (4 bits with 3 stages) and wide ones (16 bits with 10 stages).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low, clears the valid bits |
| in_valid | input | 1 | Marks `op_a`/`op_b` as a pair to multiply |
| op_a | input | WIDTH | Multiplicand, unsigned |
| op_b | input | WIDTH | Multiplier, unsigned; bit i drives row i |
| out_valid | output | 1 | Marks `product` as the result of an accepted pair |
| product | output | 2*WIDTH | Unsigned product |

## Verification
A pair driven in the cycle after rising edge k has its product and valid flag due just after edge k+`STAGES`. For the combinational variant they are due in the same cycle, one time step after the drive. The bench keeps a per-cycle history of the driven operands, valid flags and reset levels. Each cycle it samples the outputs at the falling edge and compares them with the history entry `STAGES` cycles back. That entry counts as valid only if no reset fell on any of the edges in between. The same stimulus feeds a 16-bit/10-stage instance, a 4-bit/3-stage instance and a 4-bit combinational instance, so each one is checked against its own latency.

// File: rtl/mult_pkg.sv
// Package: shared constants and the stage-placement rule for the array multiplier.
// Assumes stages <= width; boundaries after row r are numbered 0..width-1.
package mult_pkg;

    // Bit width of one lookahead group in the final adder.
    localparam int GRP_W = 4;

    // True when a register level belongs after row 'row', spreading 'stages'
    // levels evenly over 'width' row boundaries (the last one feeds the adder).
    function automatic bit reg_after(input int row, input int stages, input int width);
        return (((row + 1) * stages) / width) != ((row * stages) / width);
    endfunction

endpackage

// File: rtl/csa_cell.sv
// Module: one carry-save cell. It forms its partial-product bit with an AND gate
// and adds it to the incoming sum and carry bits with a full adder.
// Assumes nothing beyond single-bit inputs; purely combinational.
module csa_cell (
    input  logic a_bit,
    input  logic b_bit,
    input  logic s_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);
    logic pp;

    // Partial product and full-adder sum/carry.
    always_comb begin
        pp    = a_bit & b_bit;
        s_out = pp ^ s_in ^ c_in;
        c_out = (pp & s_in) | (pp & c_in) | (s_in & c_in);
    end
endmodule

// File: rtl/csa_row.sv
// Module: one row of W carry-save cells for multiplier bit ROW.
// Inputs carry the state "retired low bits + 2^ROW * (s_in + c_in)". The row adds
// a & b_bit at weight 2^ROW, retires bit ROW of the product and hands on
// the shifted sum vector and the carry vector. Combinational.
module csa_row #(
    parameter int W   = 16,
    parameter int ROW = 0
) (
    input  logic [W-1:0] a,
    input  logic         b_bit,
    input  logic [W-1:0] s_in,
    input  logic [W-1:0] c_in,
    input  logic [W-1:0] lo_in,
    output logic [W-1:0] s_out,
    output logic [W-1:0] c_out,
    output logic [W-1:0] lo_out
);
    localparam int EW = W + 2;

    logic [W-1:0] s_raw;
    logic [W-1:0] c_raw;

    for (genvar j = 0; j < W; j++) begin : g_cell
        csa_cell u_cell (
            .a_bit (a[j]),
            .b_bit (b_bit),
            .s_in  (s_in[j]),
            .c_in  (c_in[j]),
            .s_out (s_raw[j]),
            .c_out (c_raw[j])
        );
    end

    // Retire the lowest sum bit, realign the sum vector to the next weight.
    always_comb begin
        s_out  = {1'b0, s_raw[W-1:1]};
        c_out  = c_raw;
        lo_out = lo_in | (W'(s_raw[0]) << ROW);
    end

    // Arithmetic view of the row: the cells' outputs keep the running total.
    always_comb begin
        if (!$isunknown({a, b_bit, s_in, c_in})) begin
            // R1
            row_total_chk: assert ((EW'(s_raw) + (EW'(c_raw) << 1)) ==
                                   (EW'(s_in) + EW'(c_in) + EW'(a & {W{b_bit}})));
        end
    end
endmodule

// File: rtl/cla_adder.sv
// Module: two-level carry-lookahead adder, W bits, carry-in 0, carry-out dropped.
// Level one makes generate/propagate per group of GRP_W bits; level two makes
// every group carry directly from all lower groups. Combinational.
module cla_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);
    import mult_pkg::*;

    localparam int NG = (W + GRP_W - 1) / GRP_W;
    localparam int PW = NG * GRP_W;

    logic [PW-1:0] g, p, cb, sp;
    logic [NG-1:0] gg, gp;
    logic [NG:0]   gc;

    // Bit generate and propagate on zero-padded operands.
    always_comb begin
        g = PW'(x) & PW'(y);
        p = PW'(x) ^ PW'(y);
    end

    // Level one: group generate and propagate as flat sums of products.
    always_comb begin
        for (int gi = 0; gi < NG; gi++) begin
            logic acc_g;
            logic acc_p;
            acc_g = 1'b0;
            acc_p = 1'b1;
            for (int k = 0; k < GRP_W; k++) begin
                logic term;
                term = g[gi*GRP_W + k];
                for (int j = k + 1; j < GRP_W; j++) term = term & p[gi*GRP_W + j];
                acc_g = acc_g | term;
                acc_p = acc_p & p[gi*GRP_W + k];
            end
            gg[gi] = acc_g;
            gp[gi] = acc_p;
        end
    end

    // Level two: every group carry straight from lower group terms.
    always_comb begin
        gc[0] = 1'b0;
        for (int i = 1; i <= NG; i++) begin
            logic acc;
            acc = 1'b0;
            for (int k = 0; k < i; k++) begin
                logic term;
                term = gg[k];
                for (int j = k + 1; j < i; j++) term = term & gp[j];
                acc = acc | term;
            end
            gc[i] = acc;
        end
    end

    // Bit carries inside each group from the group carry-in and local terms.
    always_comb begin
        for (int gi = 0; gi < NG; gi++) begin
            for (int k = 0; k < GRP_W; k++) begin
                logic acc;
                logic chain;
                chain = gc[gi];
                for (int j = 0; j < k; j++) chain = chain & p[gi*GRP_W + j];
                acc = chain;
                for (int m = 0; m < k; m++) begin
                    logic term;
                    term = g[gi*GRP_W + m];
                    for (int j = m + 1; j < k; j++) term = term & p[gi*GRP_W + j];
                    acc = acc | term;
                end
                cb[gi*GRP_W + k] = acc;
            end
        end
    end

    // Final sum bits.
    always_comb begin
        sp  = p ^ cb;
        sum = sp[W-1:0];
    end

    // Lookahead result agrees with plain addition.
    always_comb begin
        if (!$isunknown({x, y})) begin
            // R1
            cla_sum_chk: assert (sum == W'(x + y));
        end
    end
endmodule

// File: rtl/pipe_reg.sv
// Module: one pipeline register level. The data word is not reset; the valid
// bit is cleared by the synchronous active-low reset.
// Assumes DW is the full width of everything the later rows need.
module pipe_reg #(
    parameter int DW = 80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] d,
    input  logic          vld_d,
    output logic [DW-1:0] q,
    output logic          vld_q
);
    // Capture operands and partial state every cycle.
    always_ff @(posedge clk) begin
        q <= d;
    end

    // Valid bit with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_d;
    end

    // R2
    vld_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                                   1'b1 |=> (vld_q == $past(vld_d)));
endmodule

// File: rtl/csa_array_mult.sv
// Module: top of the unsigned WIDTH x WIDTH carry-save array multiplier.
// WIDTH rows of carry-save cells, STAGES register levels spread over the row
// boundaries, and a two-level lookahead adder for the upper product half.
// Assumes 0 <= STAGES <= WIDTH. Latency is STAGES cycles; one pair per cycle.
module csa_array_mult #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [WIDTH-1:0]     op_a,
    input  logic [WIDTH-1:0]     op_b,
    output logic                 out_valid,
    output logic [2*WIDTH-1:0]   product
);
    import mult_pkg::*;

    // Boundary word: {a, b, sum, carry, retired low bits}.
    localparam int DW = 5 * WIDTH;

    logic [DW-1:0] bd [WIDTH+1];
    logic          bv [WIDTH+1];

    // Entry boundary: fresh operands, empty sum/carry state.
    always_comb begin
        bd[0] = {op_a, op_b, {(3*WIDTH){1'b0}}};
        bv[0] = in_valid;
    end

    for (genvar r = 0; r < WIDTH; r++) begin : g_row
        logic [WIDTH-1:0] ra, rb, rs, rc, rl;
        logic [WIDTH-1:0] ns, nc, nl;
        logic [DW-1:0]    nxt;

        assign {ra, rb, rs, rc, rl} = bd[r];

        csa_row #(.W(WIDTH), .ROW(r)) u_row (
            .a      (ra),
            .b_bit  (rb[r]),
            .s_in   (rs),
            .c_in   (rc),
            .lo_in  (rl),
            .s_out  (ns),
            .c_out  (nc),
            .lo_out (nl)
        );

        assign nxt = {ra, rb, ns, nc, nl};

        if (reg_after(r, STAGES, WIDTH)) begin : g_reg
            pipe_reg #(.DW(DW)) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (nxt),
                .vld_d (bv[r]),
                .q     (bd[r+1]),
                .vld_q (bv[r+1])
            );
        end else begin : g_wire
            assign bd[r+1] = nxt;
            assign bv[r+1] = bv[r];
        end
    end

    logic [WIDTH-1:0] a_end, b_end, s_end, c_end, lo_end, hi_sum;

    assign {a_end, b_end, s_end, c_end, lo_end} = bd[WIDTH];

    cla_adder #(.W(WIDTH)) u_cla (
        .x   (s_end),
        .y   (c_end),
        .sum (hi_sum)
    );

    // Assemble the product and its valid flag.
    always_comb begin
        product   = {hi_sum, lo_end};
        out_valid = bv[WIDTH];
    end

    // R1
    prod_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$isunknown({a_end, b_end})) |->
        (product == ({{WIDTH{1'b0}}, a_end} * {{WIDTH{1'b0}}, b_end})));

    // R5
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ((a_end == '0) || (b_end == '0))) |-> (product == '0));
endmodule

// File: tb/test_csa_array_mult.sv
// Bench: one stimulus stream drives a 16-bit/10-stage instance, a 4-bit/3-stage
// instance and a 4-bit combinational instance; outputs are compared at the
// falling edge against a per-cycle history of what was driven.
module test_csa_array_mult;
    localparam int S16 = 10;
    localparam int S4  = 3;
    localparam int HN  = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vin = 1'b0;
    logic [15:0] a16 = '0;
    logic [15:0] b16 = '0;

    logic        v16, v4p, v4c;
    logic [31:0] p16;
    logic [7:0]  p4p, p4c;

    int checks = 0;
    int errors = 0;
    int n = 0;

    logic        hv [HN];
    logic        hr [HN];
    logic [15:0] ha [HN];
    logic [15:0] hb [HN];
    string       ht [HN];

    localparam logic [31:0] VEC [16] = '{
        32'h0001_0001, 32'h0003_0005, 32'h00FF_00FF, 32'h1234_5678,
        32'hFFFF_0001, 32'h0001_FFFF, 32'h8000_8000, 32'hAAAA_5555,
        32'h5555_AAAA, 32'h7FFF_0002, 32'hDEAD_BEEF, 32'h0F0F_F0F0,
        32'hC3A5_0017, 32'h0010_1000, 32'hFFFE_FFFD, 32'h9E37_79B9
    };

    always #4 clk = ~clk;

    csa_array_mult #(.WIDTH(16), .STAGES(S16)) i_csa_array_mult (
        .clk(clk), .rst_n(rst_n), .in_valid(vin), .op_a(a16), .op_b(b16),
        .out_valid(v16), .product(p16));

    csa_array_mult #(.WIDTH(4), .STAGES(S4)) i_csa_array_mult_n4 (
        .clk(clk), .rst_n(rst_n), .in_valid(vin), .op_a(a16[3:0]), .op_b(b16[3:0]),
        .out_valid(v4p), .product(p4p));

    csa_array_mult #(.WIDTH(4), .STAGES(0)) i_csa_array_mult_c4 (
        .clk(clk), .rst_n(rst_n), .in_valid(vin), .op_a(a16[3:0]), .op_b(b16[3:0]),
        .out_valid(v4c), .product(p4c));

    function automatic bit exp_valid(input int at, input int s);
        if (at - s < 0) return 1'b0;
        if (!hv[at-s]) return 1'b0;
        for (int k = at - s; k < at; k++) if (!hr[k]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit rst_in_window(input int at, input int s);
        for (int k = (at - s < 0 ? 0 : at - s); k < at; k++) if (!hr[k]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Check both pipelined instances against history S cycles back.
    task automatic check_pipes(input int at);
        bit e;
        int k;
        if (at < 1) return;
        e = exp_valid(at, S16);
        chk(v16 === e, rst_in_window(at, S16) ? "R4" : "R2", "valid 16/10",
            32'(v16), 32'(e));
        if (e) begin
            k = at - S16;
            chk(p16 === 32'(ha[k]) * 32'(hb[k]), ht[k], "product 16/10",
                p16, 32'(ha[k]) * 32'(hb[k]));
        end
        e = exp_valid(at, S4);
        chk(v4p === e, rst_in_window(at, S4) ? "R4" : "R6", "valid 4/3",
            32'(v4p), 32'(e));
        if (e) begin
            k = at - S4;
            chk(p4p === 8'({4'b0, ha[k][3:0]} * {4'b0, hb[k][3:0]}), ht[k], "product 4/3",
                32'(p4p), 32'({4'b0, ha[k][3:0]} * {4'b0, hb[k][3:0]}));
        end
    endtask

    // One cycle: check due outputs, drive new inputs, check the combinational copy.
    task automatic step(input logic [15:0] a, input logic [15:0] b,
                        input logic v, input logic r, input string tag);
        @(negedge clk);
        check_pipes(n);
        a16 = a; b16 = b; vin = v; rst_n = r;
        hv[n] = v; hr[n] = r; ha[n] = a; hb[n] = b; ht[n] = tag;
        #1;
        chk(v4c === v, "R2", "valid comb", 32'(v4c), 32'(v));
        if (v) chk(p4c === 8'({4'b0, a[3:0]} * {4'b0, b[3:0]}), tag, "product comb",
                   32'(p4c), 32'({4'b0, a[3:0]} * {4'b0, b[3:0]}));
        n++;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        // R4: reset held with valid pairs offered; none may emerge.
        for (int i = 0; i < 4; i++) step(16'(i + 7), 16'(i + 3), 1'b1, 1'b0, "R4");
        // R1 / R3: table walked back to back, one pair per cycle.
        for (int i = 0; i < 16; i++) step(VEC[i][31:16], VEC[i][15:0], 1'b1, 1'b1, "R3");
        // R2: valid with gaps.
        for (int i = 0; i < 12; i++)
            step(16'(i * 911 + 5), 16'(i * 37 + 1), 1'(i % 3 == 0), 1'b1, "R2");
        // R5: zero and all-ones corners.
        step(16'h0000, 16'hBEEF, 1'b1, 1'b1, "R5");
        step(16'h1234, 16'h0000, 1'b1, 1'b1, "R5");
        step(16'h0000, 16'h0000, 1'b1, 1'b1, "R5");
        step(16'hFFFF, 16'hFFFF, 1'b1, 1'b1, "R5");
        step(16'hFFFF, 16'hFFFF, 1'b1, 1'b1, "R5");
        for (int i = 0; i < 12; i++) step(16'h0, 16'h0, 1'b0, 1'b1, "R2");
        // R4: reset in the middle of a stream kills pairs in flight.
        for (int i = 0; i < 5; i++) step(16'(i + 100), 16'(i + 200), 1'b1, 1'b1, "R4");
        step(16'h5A5A, 16'hA5A5, 1'b1, 1'b0, "R4");
        for (int i = 0; i < 12; i++) step(16'h0, 16'h0, 1'b0, 1'b1, "R4");
        // R1 / R6: every 4-bit pair, with varied upper bits for the wide copy.
        for (int i = 0; i < 256; i++)
            step({12'(i * 193), 4'(i)}, {12'(i * 71 + 5), 4'(i >> 4)}, 1'b1, 1'b1, "R1");
        for (int i = 0; i < 12; i++) step(16'h0, 16'h0, 1'b0, 1'b1, "R6");
        @(negedge clk);
        check_pipes(n);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule